// File: doc/BRIEF.md
# Hex-Keypad Memory Byte Editor

This block turns a stream of hexadecimal keypress events into a simple editor for a byte-wide static memory. Each event is a one-cycle strobe with a 4-bit digit. A mode input steers each digit either into a 16-bit address register or into an 8-bit data register. The digit enters at the least significant nibble, and the oldest nibble falls off the top. Both registers are shown bit for bit on indicator outputs.

A push button commits the data byte to the memory at the current address. The button is synchronized and edge-detected, so each press gives one write cycle. The block also reads the memory at the current address all the time and shows that byte on a separate 8-bit readback output. This lets an operator type an address, see what is stored there, type a new byte and press the button to store it. The memory is an external synchronous port: registered read data, with writes taken on the clock edge.

Top module: `hexpad_byte_editor`

## Requirements
- R1: While reset is asserted (synchronous, active low), the address indicators, the data indicators and the readback output are all zero, and no write cycle is issued.
- R2: With the mode input low, each key strobe shifts the address register left by 4 bits and loads the 4-bit code into bits [3:0]; the old bits [15:12] are dropped. The data register does not change.
- R3: With the mode input high, each key strobe shifts the data register left by 4 bits and loads the code into bits [3:0]; the old bits [7:4] are dropped. The address register does not change.
- R4: Without a key strobe, both registers hold their values, whatever the mode input does.
- R5: A button press that is held for any number of cycles gives exactly one write-enable cycle. That cycle stores the data indicator value at the address indicator value. The pulse comes three clock edges after the button input rises.
- R6: If a key strobe occurs in the cycle where the write pulse would occur, the write for that press is dropped, and the memory keeps its old contents.
- R7: The readback output shows the memory byte at the current address. It is updated two clock edges after the address settles: one edge for the memory read and one for the output register.
- R8: The memory address and memory write-data outputs always equal the address and data indicators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_stb | input | 1 | One-cycle keypress strobe |
| key_code | input | 4 | Hex digit of the keypress |
| sel_data | input | 1 | 0: digits go to address, 1: digits go to data |
| wr_btn | input | 1 | Asynchronous write push button, active high |
| addr_led | output | 16 | Address register, one bit per indicator |
| data_led | output | 8 | Data register, one bit per indicator |
| rd_led | output | 8 | Byte read from memory at the current address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable, one cycle per press |
| mem_rdata | input | 8 | Registered memory read data |

## Verification
A corrupted address or data register shows up on the indicators at the negative edge that follows the strobe, because each register sits one edge behind its port. A wrong readback path, or a wrong write-enable path, stays hidden until the address is revisited. It then shows up on the readback output within two edges. The sweeps therefore re-read every written location. Faults in the synchronizer or the edge detector show up in the count of write pulses for each press. A faulty suppression path shows up as a changed byte at a location that should have kept its old value.

// File: rtl/hexpad_byte_editor.sv
module hexpad_byte_editor #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NIB    = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_stb,
  input  logic [NIB-1:0]    key_code,
  input  logic              sel_data,
  input  logic              wr_btn,
  output logic [ADDR_W-1:0] addr_led,
  output logic [DATA_W-1:0] data_led,
  output logic [DATA_W-1:0] rd_led,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              btn_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (key_stb) begin
      if (sel_data) data_q <= {data_q[DATA_W-NIB-1:0], key_code};
      else          addr_q <= {addr_q[ADDR_W-NIB-1:0], key_code};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      rd_led <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], wr_btn};
      prev_q <= sync_q[SYNC_N-1];
      rd_led <= mem_rdata;
    end
  end

  assign btn_rise  = sync_q[SYNC_N-1] & ~prev_q;
  assign mem_we    = rst_n & btn_rise & ~key_stb;
  assign addr_led  = addr_q;
  assign data_led  = data_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r5_after_button: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && mem_we |-> $past(wr_btn, 2));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_stb |=> $stable(addr_led) && $stable(data_led));
  a_r2_addr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    key_stb && !sel_data |=> addr_led[NIB-1:0] == $past(key_code) && $stable(data_led));
  a_r3_data_shift: assert property (@(posedge clk) disable iff (!rst_n)
    key_stb && sel_data |=> data_led[NIB-1:0] == $past(key_code) && $stable(addr_led));
  a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rd_led == $past(mem_rdata));
endmodule

// File: tb/sim_hexpad_byte_editor.sv
`timescale 1ns/1ps
module sim_hexpad_byte_editor;
  logic clk = 0, rst_n = 0, key_stb = 0, sel_data = 0, wr_btn = 0;
  logic [3:0] key_code = 0;
  logic [15:0] addr_led, mem_addr;
  logic [7:0] data_led, rd_led, mem_wdata, mem_rdata;
  logic mem_we;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int checks = 0, errors = 0, we_cnt = 0;

  always #2.5 clk = ~clk;

  hexpad_byte_editor u0 (.clk, .rst_n, .key_stb, .key_code, .sel_data, .wr_btn,
    .addr_led, .data_led, .rd_led, .mem_addr, .mem_wdata, .mem_we, .mem_rdata);

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic key(input logic [3:0] c);
    @(negedge clk); key_stb = 1; key_code = c;
    @(negedge clk); key_stb = 0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    sel_data = 0;
    for (int i = 3; i >= 0; i--) key(a[i*4 +: 4]);
  endtask

  task automatic set_data(input logic [7:0] d);
    sel_data = 1;
    for (int i = 1; i >= 0; i--) key(d[i*4 +: 4]);
  endtask

  task automatic press(input int hold);
    @(negedge clk); wr_btn = 1;
    repeat (hold) @(negedge clk);
    wr_btn = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readback(input logic [15:0] a, input string req);
    set_addr(a);
    repeat (3) @(negedge clk);
    chk(rd_led == exp_mem[a[7:0]], req, rd_led, exp_mem[a[7:0]]);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ea;
    logic [7:0] ed;
    int w0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    // R1
    chk(addr_led == 0 && data_led == 0 && rd_led == 0, "R1 reset", {addr_led, data_led}, 0);
    chk(we_cnt == 0, "R1 no write", we_cnt, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R8 sweep all codes
    ea = 0; ed = 0; sel_data = 0;
    for (int c = 0; c < 16; c++) begin
      key(4'(c ^ 5));
      ea = {ea[11:0], 4'(c ^ 5)};
      chk(addr_led == ea && data_led == ed, "R2 addr shift", {addr_led, data_led}, {ea, ed});
      chk(mem_addr == addr_led, "R8 mem_addr", mem_addr, addr_led);
    end
    // R3 sweep
    sel_data = 1;
    for (int c = 15; c >= 0; c--) begin
      key(4'(c));
      ed = {ed[3:0], 4'(c)};
      chk(data_led == ed && addr_led == ea, "R3 data shift", {addr_led, data_led}, {ea, ed});
      chk(mem_wdata == data_led, "R8 mem_wdata", mem_wdata, data_led);
    end
    // R4
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sel_data = ~sel_data; key_code = 4'(k);
    end
    repeat (2) @(negedge clk);
    chk(addr_led == ea && data_led == ed, "R4 hold", {addr_led, data_led}, {ea, ed});

    // R5 / R7 writes sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = 16'h1200 + 16'(i * 17);
      d = 8'(i * 37 + 5);
      set_addr(a); set_data(d);
      w0 = we_cnt;
      press(2 + i);
      exp_mem[a[7:0]] = d;
      chk(we_cnt == w0 + 1, "R5 one pulse", we_cnt - w0, 1);
    end
    for (int i = 0; i < 16; i++) readback(16'h1200 + 16'(i * 17), "R7 readback");
    readback(16'h0003, "R7 unwritten");

    // R6 suppression
    set_addr(16'h1211); set_data(8'hEE);
    w0 = we_cnt;
    @(negedge clk); wr_btn = 1;
    @(negedge clk); @(negedge clk);
    sel_data = 1; key_stb = 1; key_code = 4'h3;
    @(negedge clk); key_stb = 0;
    repeat (4) @(negedge clk); wr_btn = 0;
    repeat (4) @(negedge clk);
    chk(we_cnt == w0, "R6 suppressed", we_cnt - w0, 0);
    chk(data_led == 8'hE3, "R6 key taken", data_led, 8'hE3);
    readback(16'h1211, "R6 memory kept");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule